// File: doc/BRIEF.md
# Coprocessor Conditional Trap Sequencer

This block runs the main-processor side of an instruction that traps when a coprocessor reports that a condition holds. It takes the instruction's first word from a fetch handshake and decodes it. If the word is this instruction and its opmode is legal, the block takes the next word, which holds the condition selector. It writes that word to the coprocessor's condition register over a small valid/ready register bus. It then polls the coprocessor's response register until it gets a final answer.

While polling, the coprocessor may answer "busy" or ask for a service. A service request is passed out on `service_req`, and polling resumes once `service_done` arrives. A final "true" answer ends the instruction with a trap request. A final "false" answer ends it normally. In both cases the block reports how many bytes the program counter must advance. That count covers the two fixed words, any extension words the coprocessor defines, and the optional operand words selected by the opmode. The block never reads the operand words.

Top module: `cptrap_seq`

## Requirements
- R1: A fetched word is taken as this instruction only when bits [15:12] are 1111 and bits [8:3] are 001111. Bits [11:9] then appear on `cp_id` for the rest of the sequence. Any other word is consumed and dropped: no bus access, no pulse, and the block stays ready for a new first word.
- R2: The opmode in bits [2:0] of the first word selects the operand-word count: 3'b010 gives one word, 3'b011 gives two, and 3'b100 gives none.
- R3: Any other opmode produces `illegal` and `done` in the same cycle, with `trap` low and `pc_increment` zero. No second word is fetched and no bus access is made.
- R4: The second word is written unchanged to bus address 0 (the condition register) with `bus_req_write` high, including when its bits [15:6] are nonzero. This is the only write in the sequence.
- R5: After the write, the block reads bus address 1 (the response register). A response of 0x0001, or any value not listed in R6 and R7, causes another read.
- R6: A response of 0x0004 raises `service_req`. While it is high there are no bus requests. The next read is issued only after `service_done`.
- R7: A response of 0x0003 ends the instruction with `done` and `trap` both high. A response of 0x0002 ends it with `done` high and `trap` low.
- R8: On a final response, `pc_increment` equals 4 + 2 × (extension words + operand words). The extension-word count is the value of `ext_words` sampled in the cycle the final response arrives.
- R9: A bus request holds its valid, direction, address and data steady until `bus_req_ready` accepts it. A new request is issued only after the previous one has completed.
- R10: `done`, `trap`, `illegal` and a nonzero `pc_increment` last exactly one cycle and occur only while `done` is high. After `done` the block is ready for a new first word.
- R11: A synchronous active-high `rst` returns the block to idle from any point in the sequence. In idle, `iw_ready` is high and all bus, service and result outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iw_valid | input | 1 | Fetch word valid |
| iw_data | input | 16 | Fetch word |
| iw_ready | output | 1 | Block accepts the fetch word this cycle |
| bus_req_valid | output | 1 | Register bus request valid |
| bus_req_write | output | 1 | 1 = write, 0 = read |
| bus_req_addr | output | 2 | 0 = condition register, 1 = response register |
| bus_req_wdata | output | 16 | Write data (selector word) |
| bus_req_ready | input | 1 | Bus accepts the request |
| bus_rsp_valid | input | 1 | Read data returned |
| bus_rsp_rdata | input | 16 | Response register value |
| ext_words | input | EXT_W | Coprocessor extension-word count |
| service_req | output | 1 | Coprocessor requested a service |
| service_done | input | 1 | Requested service finished |
| cp_id | output | 3 | Coprocessor ID of the current instruction |
| done | output | 1 | Instruction finished (pulse) |
| trap | output | 1 | Trap request (pulse) |
| illegal | output | 1 | Illegal opmode (pulse) |
| pc_increment | output | PCI_W | Bytes to advance the program counter (pulse) |

## Verification
The assertions check every cycle that a stalled bus request holds steady and that writes go only to address 0 and reads only to address 1. They also check that the result flags appear only inside a one-cycle `done` that never carries `trap` and `illegal` together, that an illegal result has zero length, and that the bus stays quiet while a service is pending. Only the bench scenarios can show which response code leads to which outcome, the exact byte count for each opmode and extension count, the selector word passed through unchanged with nonzero upper bits, dropped non-matching words, and recovery from a reset in the middle of polling.

// File: rtl/cptrap_pkg.sv
package cptrap_pkg;

    localparam int WORD_W = 16;

    localparam logic [3:0] FLINE_NIB  = 4'b1111;
    localparam logic [5:0] TRAP_SIG   = 6'b001111;

    localparam logic [1:0] ADDR_COND  = 2'd0;
    localparam logic [1:0] ADDR_RESP  = 2'd1;

    localparam logic [15:0] RSP_BUSY  = 16'h0001;
    localparam logic [15:0] RSP_FALSE = 16'h0002;
    localparam logic [15:0] RSP_TRUE  = 16'h0003;
    localparam logic [15:0] RSP_SVC   = 16'h0004;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_WR,
        ST_RDQ,
        ST_RDW,
        ST_SVC,
        ST_FIN
    } state_e;

    typedef enum logic [1:0] {
        RC_BUSY,
        RC_FALSE,
        RC_TRUE,
        RC_SVC
    } resp_e;

    typedef struct packed {
        logic       is_trap;
        logic       op_ok;
        logic [2:0] cp_id;
        logic [1:0] op_words;
    } dec_t;

    typedef struct packed {
        logic trap;
        logic illegal;
    } outcome_t;

    // {legal, operand word count}
    function automatic logic [2:0] opmode_lookup(input logic [2:0] m);
        case (m)
            3'b010:  return 3'b1_01;
            3'b011:  return 3'b1_10;
            3'b100:  return 3'b1_00;
            default: return 3'b0_00;
        endcase
    endfunction

endpackage

// File: rtl/cptrap_decode.sv
module cptrap_decode
    import cptrap_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    logic [2:0] lk;

    always_comb begin
        lk           = opmode_lookup(word[2:0]);
        dec.is_trap  = (word[15:12] == FLINE_NIB) && (word[8:3] == TRAP_SIG);
        dec.op_ok    = lk[2];
        dec.op_words = lk[1:0];
        dec.cp_id    = word[11:9];
    end
endmodule

// File: rtl/cptrap_resp.sv
module cptrap_resp
    import cptrap_pkg::*;
(
    input  logic [WORD_W-1:0] rdata,
    output resp_e             kind
);
    always_comb begin
        case (rdata)
            RSP_FALSE: kind = RC_FALSE;
            RSP_TRUE:  kind = RC_TRUE;
            RSP_SVC:   kind = RC_SVC;
            default:   kind = RC_BUSY;   // busy and unknown codes both poll again
        endcase
    end
endmodule

// File: rtl/cptrap_len.sv
module cptrap_len #(
    parameter int EXT_W = 3,
    parameter int PCI_W = 5
) (
    input  logic [EXT_W-1:0] ext_words,
    input  logic [1:0]       op_words,
    output logic [PCI_W-1:0] inc
);
    logic [PCI_W-1:0] extra;

    always_comb begin
        extra = PCI_W'(ext_words) + PCI_W'(op_words);
        inc   = PCI_W'(4) + (extra << 1);
    end
endmodule

// File: rtl/cptrap_seq.sv
module cptrap_seq
    import cptrap_pkg::*;
#(
    parameter int EXT_W = 3,
    parameter int PCI_W = $clog2(4 + 2 * ((1 << EXT_W) - 1 + 2) + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 iw_valid,
    input  logic [WORD_W-1:0]    iw_data,
    output logic                 iw_ready,
    output logic                 bus_req_valid,
    output logic                 bus_req_write,
    output logic [1:0]           bus_req_addr,
    output logic [WORD_W-1:0]    bus_req_wdata,
    input  logic                 bus_req_ready,
    input  logic                 bus_rsp_valid,
    input  logic [WORD_W-1:0]    bus_rsp_rdata,
    input  logic [EXT_W-1:0]     ext_words,
    output logic                 service_req,
    input  logic                 service_done,
    output logic [2:0]           cp_id,
    output logic                 done,
    output logic                 trap,
    output logic                 illegal,
    output logic [PCI_W-1:0]     pc_increment
);

    state_e            state_q;
    dec_t              dec;
    resp_e             kind;
    logic [PCI_W-1:0]  len_inc;
    logic [1:0]        opw_q;
    logic [2:0]        cpid_q;
    logic [WORD_W-1:0] sel_q;
    outcome_t          out_q;
    logic [PCI_W-1:0]  inc_q;

    cptrap_decode u_decode (
        .word (iw_data),
        .dec  (dec)
    );

    cptrap_resp u_resp (
        .rdata (bus_rsp_rdata),
        .kind  (kind)
    );

    cptrap_len #(
        .EXT_W (EXT_W),
        .PCI_W (PCI_W)
    ) u_len (
        .ext_words (ext_words),
        .op_words  (opw_q),
        .inc       (len_inc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            opw_q   <= '0;
            cpid_q  <= '0;
            sel_q   <= '0;
            out_q   <= '0;
            inc_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (iw_valid && dec.is_trap) begin
                        cpid_q <= dec.cp_id;
                        opw_q  <= dec.op_words;
                        if (dec.op_ok) begin
                            state_q <= ST_SEL;
                        end else begin
                            out_q   <= '{trap: 1'b0, illegal: 1'b1};
                            inc_q   <= '0;
                            state_q <= ST_FIN;
                        end
                    end
                end
                ST_SEL: begin
                    if (iw_valid) begin
                        sel_q   <= iw_data;
                        state_q <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (bus_req_ready) state_q <= ST_RDQ;
                end
                ST_RDQ: begin
                    if (bus_req_ready) state_q <= ST_RDW;
                end
                ST_RDW: begin
                    if (bus_rsp_valid) begin
                        case (kind)
                            RC_TRUE, RC_FALSE: begin
                                out_q   <= '{trap: (kind == RC_TRUE), illegal: 1'b0};
                                inc_q   <= len_inc;
                                state_q <= ST_FIN;
                            end
                            RC_SVC:  state_q <= ST_SVC;
                            default: state_q <= ST_RDQ;
                        endcase
                    end
                end
                ST_SVC: begin
                    if (service_done) state_q <= ST_RDQ;
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                    out_q   <= '0;
                    inc_q   <= '0;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        iw_ready      = (state_q == ST_IDLE) || (state_q == ST_SEL);
        bus_req_valid = (state_q == ST_WR) || (state_q == ST_RDQ);
        bus_req_write = (state_q == ST_WR);
        bus_req_addr  = (state_q == ST_WR) ? ADDR_COND :
                        (state_q == ST_RDQ) ? ADDR_RESP : 2'd0;
        bus_req_wdata = (state_q == ST_WR) ? sel_q : '0;
        service_req   = (state_q == ST_SVC);
        cp_id         = cpid_q;
        done          = (state_q == ST_FIN);
        trap          = done && out_q.trap;
        illegal       = done && out_q.illegal;
        pc_increment  = done ? inc_q : '0;
    end

endmodule

// File: rtl/cptrap_chk.sv
module cptrap_chk #(
    parameter int PCI_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             iw_ready,
    input logic             bus_req_valid,
    input logic             bus_req_write,
    input logic [1:0]       bus_req_addr,
    input logic [15:0]      bus_req_wdata,
    input logic             bus_req_ready,
    input logic             service_req,
    input logic             done,
    input logic             trap,
    input logic             illegal,
    input logic [PCI_W-1:0] pc_increment
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid && !bus_req_ready |=>
            bus_req_valid && $stable(bus_req_write) && $stable(bus_req_addr) && $stable(bus_req_wdata)); // R9

    AST_ADDR_MAP: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> (bus_req_write ? (bus_req_addr == 2'd0) : (bus_req_addr == 2'd1))); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_FLAGS_IN_DONE: assert property (@(posedge clk) disable iff (rst)
        (trap || illegal || (pc_increment != '0)) |-> done); // R10

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        done |-> !(trap && illegal)); // R7

    AST_ILLEGAL_NO_LEN: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (pc_increment == '0) && !bus_req_valid); // R3

    AST_SERVICE_QUIET: assert property (@(posedge clk) disable iff (rst)
        service_req |-> !bus_req_valid && !iw_ready); // R6

    AST_LEN_SHAPE: assert property (@(posedge clk) disable iff (rst)
        done && !illegal |-> (pc_increment >= PCI_W'(4)) && !pc_increment[0]); // R8

endmodule

bind cptrap_seq cptrap_chk #(.PCI_W(PCI_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .iw_ready      (iw_ready),
    .bus_req_valid (bus_req_valid),
    .bus_req_write (bus_req_write),
    .bus_req_addr  (bus_req_addr),
    .bus_req_wdata (bus_req_wdata),
    .bus_req_ready (bus_req_ready),
    .service_req   (service_req),
    .done          (done),
    .trap          (trap),
    .illegal       (illegal),
    .pc_increment  (pc_increment)
);

// File: tb/test_cptrap_seq.sv
`timescale 1ns/1ps
module test_cptrap_seq;

    localparam int EXT_W = 3;
    localparam int PCI_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             iw_valid = 1'b0;
    logic [15:0]      iw_data = '0;
    logic             iw_ready;
    logic             bus_req_valid, bus_req_write;
    logic [1:0]       bus_req_addr;
    logic [15:0]      bus_req_wdata;
    logic             bus_req_ready;
    logic             bus_rsp_valid;
    logic [15:0]      bus_rsp_rdata;
    logic [EXT_W-1:0] ext_words = '0;
    logic             service_req;
    logic             service_done;
    logic [2:0]       cp_id;
    logic             done, trap, illegal;
    logic [PCI_W-1:0] pc_increment;

    int n_cmp = 0;
    int n_bad = 0;

    // coprocessor model controls (written by tasks only)
    logic [15:0] script [8];
    int          slen = 1;
    int          rd_base = 0;
    bit          stall_mode = 1'b0;

    // coprocessor model state (written by model only)
    int          wr_cnt = 0, rd_cnt = 0, svc_cnt = 0, busy_in_svc = 0;
    logic [15:0] last_wdata = '0;
    logic [2:0]  last_cpid = '0;
    logic [1:0]  free_cyc = '0;
    int          svc_wait = 0;

    always #4 clk = ~clk;

    cptrap_seq #(.EXT_W(EXT_W), .PCI_W(PCI_W)) i_cptrap_seq (
        .clk(clk), .rst(rst),
        .iw_valid(iw_valid), .iw_data(iw_data), .iw_ready(iw_ready),
        .bus_req_valid(bus_req_valid), .bus_req_write(bus_req_write),
        .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
        .bus_req_ready(bus_req_ready),
        .bus_rsp_valid(bus_rsp_valid), .bus_rsp_rdata(bus_rsp_rdata),
        .ext_words(ext_words),
        .service_req(service_req), .service_done(service_done),
        .cp_id(cp_id), .done(done), .trap(trap), .illegal(illegal),
        .pc_increment(pc_increment)
    );

    assign bus_req_ready = !stall_mode || (free_cyc == 2'b11);

    function automatic logic [15:0] pick(input int k);
        int j = k - rd_base;
        if (j >= slen) j = slen - 1;
        if (j < 0) j = 0;
        return script[j];
    endfunction

    always @(posedge clk) begin
        free_cyc <= free_cyc + 2'd1;
        if (rst) begin
            bus_rsp_valid <= 1'b0;
            bus_rsp_rdata <= '0;
            service_done  <= 1'b0;
            svc_wait      <= 0;
        end else begin
            bus_rsp_valid <= 1'b0;
            if (bus_req_valid && bus_req_ready) begin
                if (bus_req_write) begin
                    wr_cnt     <= wr_cnt + 1;
                    last_wdata <= bus_req_wdata;
                    last_cpid  <= cp_id;
                end else begin
                    rd_cnt        <= rd_cnt + 1;
                    bus_rsp_valid <= 1'b1;
                    bus_rsp_rdata <= pick(rd_cnt);
                end
            end
            if (service_req && bus_req_valid) busy_in_svc <= busy_in_svc + 1;
            if (service_req) begin
                if (svc_wait == 0) svc_cnt <= svc_cnt + 1;
                svc_wait <= svc_wait + 1;
            end else begin
                svc_wait <= 0;
            end
            service_done <= service_req && (svc_wait == 3);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [2:0] id, input logic [2:0] m);
        return {4'b1111, id, 6'b001111, m};
    endfunction

    task automatic send_word(input logic [15:0] w);
        @(negedge clk);
        iw_valid = 1'b1;
        iw_data  = w;
        while (!iw_ready) @(negedge clk);
        @(negedge clk);
        iw_valid = 1'b0;
    endtask

    task automatic wait_done(output bit got, output bit t, output bit il, output int pc);
        got = 1'b0; t = 1'b0; il = 1'b0; pc = 0;
        for (int k = 0; k < 400; k++) begin
            if (done) begin
                got = 1'b1; t = trap; il = illegal; pc = int'(pc_increment);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic legal_run(input logic [15:0] w0, input logic [15:0] w1, input int ext,
                             input bit exp_trap, input int exp_pc, input int exp_rd,
                             input int exp_svc, input string tag);
        int wr0 = wr_cnt, rd0 = rd_cnt, sv0 = svc_cnt;
        bit got, t, il;
        int pc;
        rd_base   = rd_cnt;
        ext_words = EXT_W'(ext);
        send_word(w0);
        send_word(w1);
        wait_done(got, t, il, pc);
        check(got, {tag, " R7 done seen"}, int'(got), 1);
        check(t == exp_trap && !il, {tag, " R7 trap outcome"}, int'(t), int'(exp_trap));
        check(pc == exp_pc, {tag, " R8 pc_increment"}, pc, exp_pc);
        check(wr_cnt - wr0 == 1, {tag, " R4 single write"}, wr_cnt - wr0, 1);
        check(last_wdata == w1, {tag, " R4 selector word"}, int'(last_wdata), int'(w1));
        check(last_cpid == w0[11:9], {tag, " R1 cp_id"}, int'(last_cpid), int'(w0[11:9]));
        check(rd_cnt - rd0 == exp_rd, {tag, " R5 read count"}, rd_cnt - rd0, exp_rd);
        check(svc_cnt - sv0 == exp_svc, {tag, " R6 service count"}, svc_cnt - sv0, exp_svc);
        @(negedge clk);
        check(!done && !trap && pc_increment == '0, {tag, " R10 pulse width"}, int'(done), 0);
        check(iw_ready, {tag, " R10 back to idle"}, int'(iw_ready), 1);
    endtask

    task automatic t_reset;
        check(!done && !trap && !illegal && pc_increment == '0, "R11 reset results", int'(done), 0);
        check(!bus_req_valid && !service_req && iw_ready, "R11 reset idle", int'(bus_req_valid), 0);
    endtask

    task automatic t_false_zero_ops;   // R2 opmode 100, R7 false
        script[0] = 16'h0002; slen = 1;
        legal_run(mk(3'd5, 3'b100), 16'h0012, 0, 1'b0, 4, 1, 0, "false/op0");
    endtask

    task automatic t_true_busy_one_op; // R5 busy polls, R2 opmode 010
        script[0] = 16'h0001; script[1] = 16'h0001; script[2] = 16'h0003; slen = 3;
        legal_run(mk(3'd2, 3'b010), 16'h003F, 2, 1'b1, 10, 3, 0, "true/op1");
    endtask

    task automatic t_service_two_ops;  // R6 service, R4 upper bits, R2 opmode 011
        script[0] = 16'h0004; script[1] = 16'h0002; slen = 2;
        legal_run(mk(3'd7, 3'b011), 16'hFFC5, 7, 1'b0, 22, 2, 1, "svc/op2");
        check(busy_in_svc == 0, "R6 bus quiet during service", busy_in_svc, 0);
    endtask

    task automatic t_stall_unknown;    // R9 stalls, R5 unknown code
        stall_mode = 1'b1;
        script[0] = 16'h0055; script[1] = 16'h0004; script[2] = 16'h0003; slen = 3;
        legal_run(mk(3'd0, 3'b010), 16'h0007, 1, 1'b1, 8, 3, 1, "stall/unknown");
        stall_mode = 1'b0;
    endtask

    task automatic t_illegal_opmode;   // R3
        int wr0 = wr_cnt, rd0 = rd_cnt;
        bit got, t, il;
        int pc;
        send_word(mk(3'd1, 3'b101));
        wait_done(got, t, il, pc);
        check(got && il && !t, "R3 illegal flagged", int'(il), 1);
        check(pc == 0, "R3 zero length", pc, 0);
        @(negedge clk);
        check(!illegal && !done, "R10 illegal pulse width", int'(illegal), 0);
        repeat (4) @(negedge clk);
        check(wr_cnt == wr0 && rd_cnt == rd0, "R3 no bus access", wr_cnt - wr0, 0);
        check(iw_ready, "R3 waits for new first word", int'(iw_ready), 1);
    endtask

    task automatic t_foreign_words;    // R1
        int wr0 = wr_cnt, rd0 = rd_cnt;
        int pulses = 0;
        send_word(16'h1078);           // right signature, wrong top nibble
        send_word(16'hF0C2);           // right top nibble, wrong signature
        for (int k = 0; k < 10; k++) begin
            if (done || illegal || bus_req_valid) pulses++;
            @(negedge clk);
        end
        check(pulses == 0, "R1 foreign words ignored", pulses, 0);
        check(wr_cnt == wr0 && rd_cnt == rd0, "R1 no bus access", wr_cnt - wr0, 0);
        check(iw_ready, "R1 still idle", int'(iw_ready), 1);
    endtask

    task automatic t_reset_midway;     // R11
        script[0] = 16'h0001; slen = 1;
        rd_base = rd_cnt;
        send_word(mk(3'd4, 3'b100));
        send_word(16'h0001);
        repeat (15) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!bus_req_valid && !service_req && iw_ready, "R11 mid-sequence reset", int'(bus_req_valid), 0);
        check(!done && !trap && !illegal, "R11 reset clears results", int'(done), 0);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_false_zero_ops();
        t_true_busy_one_op();
        t_service_two_ops();
        t_illegal_opmode();
        t_foreign_words();
        t_reset_midway();
        t_stall_unknown();
        t_false_zero_ops();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule